// File: doc/BRIEF.md
# Event Interrupt and Statistics Controller

This block sits behind a detection engine that classifies incoming pulses. The engine passes it one-cycle strobes for a classified lightning, a classified disturber and a distance update that old events aged out of the history. It also passes a level that is high while the background noise is too high. The block picks which of these reach the host. It holds a 4-bit cause value and an active-high interrupt line. The host clears both by pulsing a read strobe.

Two rules gate the strobes. The first is a dead period. Each accepted disturber or lightning opens a fixed lockout, counted in ticks of a slow timer, and any disturber or lightning strobe that arrives during the lockout is dropped. The second is a statistics gate on lightning. The block keeps a ring of per-minute event counts that spans a window of minutes. A lightning event raises the interrupt only when the window holds at least the selected minimum number of events, counting the new one. A rising edge on the clear-statistics input empties the history. With the default input levels held, the host drives that input low and then high again.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, `cause` reads 0000 and `irq` is low.
- R2: Each posted event is encoded in `cause` as follows: lightning 1000, disturber 0100, noise too high 0001, distance update 0000 with `irq` high. Outputs change on the clock edge that samples the strobe.
- R3: A posted event sets `irq` high. A pulse on `cause_rd` clears `irq` and the stored cause on the next edge. If an event is posted on that same edge, the new event is kept.
- R4: A rising edge of `noise_hi` posts the noise cause. While `noise_hi` stays high and no higher cause is stored, `cause` reads 0001, even after a read. `irq` is raised again only by a new rising edge.
- R5: While `mask_dis` is 1, an accepted disturber does not change `cause` or `irq`. It still starts its lockout.
- R6: `min_sel` sets the minimum lightning count: 00 gives 1, 01 gives 5, 10 gives 9 and 11 gives 16. A lightning event posts only if the window count, including this event, reaches that minimum. Every accepted lightning is counted, whether or not it posts.
- R7: The window covers the current minute and the WIN_SLOTS-1 minutes before it. A minute is TICKS_PER_MIN ticks. Events from older minutes no longer count.
- R8: An accepted disturber opens a lockout of DIS_LOCK_TICKS ticks. An accepted lightning opens a lockout of LIG_LOCK_TICKS ticks. While a lockout is open, lightning and disturber strobes are neither posted nor counted. Without ticks the lockout does not expire. If both strobes come on the same edge, the lightning is taken.
- R9: A rising edge of `clr_stat` empties the event history. The input resets as if it had been high, so only a high-low-high sequence clears.
- R10: A stored cause is overwritten only by an event of equal or higher priority. Lightning ranks highest, then disturber, then noise, then distance update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe from the slow timer |
| noise_hi | input | 1 | Level, high while the noise floor is too high |
| lig_evt | input | 1 | Strobe for a classified lightning |
| dis_evt | input | 1 | Strobe for a classified disturber |
| dist_evt | input | 1 | Strobe for a distance update from aged-out history |
| mask_dis | input | 1 | 1 keeps disturbers from interrupting |
| min_sel | input | 2 | Minimum lightning count setting |
| clr_stat | input | 1 | Clear-statistics control, acts on its rising edge |
| cause_rd | input | 1 | Host read strobe for the cause register |
| cause | output | 4 | Interrupt cause code |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench drives lightning trains that stop one event short of each minimum count. A gate that compares with the wrong bound, or leaves out the new event, posts one event early or one event late. It also lets a partial history age past the window and checks that the stale minutes no longer count. A ring that fails to zero the slot it reuses would fire too early there. Strobes land inside a lockout, including a lockout whose ticks are withheld, and those strobes must leave the outputs and the history untouched. The bench also issues a read on the same edge as a new event, and posts causes of lower priority over higher ones. A design with the wrong order of updates loses the new event, and a design with the wrong ranking replaces the stored cause.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef logic [3:0] cause_t;

  localparam cause_t CAUSE_NONE  = 4'b0000;
  localparam cause_t CAUSE_NOISE = 4'b0001;
  localparam cause_t CAUSE_DIS   = 4'b0100;
  localparam cause_t CAUSE_LIG   = 4'b1000;

  // rank of a posted event: 0 none, 1 distance, 2 noise, 3 disturber, 4 lightning
  typedef logic [2:0] rank_t;

  function automatic logic [4:0] min_lightning(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd5;
      2'b10:   return 5'd9;
      default: return 5'd16;
    endcase
  endfunction

  function automatic cause_t rank_code(input rank_t r);
    case (r)
      3'd4:    return CAUSE_LIG;
      3'd3:    return CAUSE_DIS;
      3'd2:    return CAUSE_NOISE;
      default: return CAUSE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/evt_lockout.sv
module evt_lockout #(
  parameter int DIS_TICKS = 49152,
  parameter int LIG_TICKS = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ld_lig_i,
  input  logic ld_dis_i,
  output logic locked_o
);
  localparam int MAXT   = (DIS_TICKS > LIG_TICKS) ? DIS_TICKS : LIG_TICKS;
  localparam int LOCK_W = $clog2(MAXT + 1);

  logic [LOCK_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (ld_lig_i)              cnt_q <= LOCK_W'(LIG_TICKS);
    else if (ld_dis_i)              cnt_q <= LOCK_W'(DIS_TICKS);
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign locked_o = (cnt_q != '0);

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !tick_i) |=> $stable(cnt_q)); // R8
  AST_LOCK_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > LOCK_W'(1)) |=> (cnt_q <= $past(cnt_q))); // R8
endmodule

// File: rtl/evt_window.sv
module evt_window #(
  parameter int TICKS_PER_MIN = 1966080,
  parameter int WIN_SLOTS     = 15,
  parameter int SLOT_W        = 6,
  localparam int SUM_W        = $clog2(WIN_SLOTS * ((1 << SLOT_W) - 1) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [SUM_W-1:0] sum_o
);
  localparam int IDX_W = (WIN_SLOTS > 1) ? $clog2(WIN_SLOTS) : 1;
  localparam int CNT_W = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic [CNT_W-1:0]  tcnt_q;
  logic [IDX_W-1:0]  idx_q, idx_nxt;
  logic [SLOT_W-1:0] slot_q [WIN_SLOTS];
  logic              adv;

  assign adv     = tick_i && (tcnt_q == CNT_W'(TICKS_PER_MIN - 1));
  assign idx_nxt = (idx_q == IDX_W'(WIN_SLOTS - 1)) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      idx_q  <= '0;
    end else if (tick_i) begin
      tcnt_q <= adv ? '0 : tcnt_q + 1'b1;
      if (adv) idx_q <= idx_nxt;
    end
  end

  // the slot entered on a minute boundary is the oldest one; it restarts at zero
  always_ff @(posedge clk) begin
    for (int i = 0; i < WIN_SLOTS; i++) begin
      if (!rst_n || clr_i)
        slot_q[i] <= '0;
      else if (adv && idx_nxt == IDX_W'(i))
        slot_q[i] <= inc_i ? SLOT_W'(1) : '0;
      else if (!adv && idx_q == IDX_W'(i) && inc_i && slot_q[i] != SLOT_MAX)
        slot_q[i] <= slot_q[i] + 1'b1;
    end
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < WIN_SLOTS; i++) sum_o = sum_o + SUM_W'(slot_q[i]);
  end

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sum_o == '0)); // R9
  AST_SUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr_i) |=> (sum_o <= $past(sum_o) + SUM_W'(1))); // R7
endmodule

// File: rtl/evt_cause.sv
module evt_cause
  import evt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rd_i,
  input  logic   noise_lvl_i,
  input  logic   post_lig_i,
  input  logic   post_dis_i,
  input  logic   post_dist_i,
  output cause_t cause_o,
  output logic   irq_o
);
  cause_t code_q;
  logic   irq_q, noise_prev_q, post_noise;
  rank_t  cur_rank, base_rank, new_rank;

  assign post_noise = noise_lvl_i && !noise_prev_q;

  always_comb begin
    case (code_q)
      CAUSE_LIG:   cur_rank = 3'd4;
      CAUSE_DIS:   cur_rank = 3'd3;
      CAUSE_NOISE: cur_rank = 3'd2;
      default:     cur_rank = irq_q ? 3'd1 : 3'd0;
    endcase
    base_rank = rd_i ? 3'd0 : cur_rank;
    if (post_lig_i)       new_rank = 3'd4;
    else if (post_dis_i)  new_rank = 3'd3;
    else if (post_noise)  new_rank = 3'd2;
    else if (post_dist_i) new_rank = 3'd1;
    else                  new_rank = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q       <= CAUSE_NONE;
      irq_q        <= 1'b0;
      noise_prev_q <= 1'b0;
    end else begin
      noise_prev_q <= noise_lvl_i;
      if (new_rank != 3'd0 && new_rank >= base_rank) begin
        code_q <= rank_code(new_rank);
        irq_q  <= 1'b1;
      end else if (rd_i) begin
        code_q <= CAUSE_NONE;
        irq_q  <= 1'b0;
      end
    end
  end

  // a live noise level shows through once the stored cause is empty
  assign cause_o = (code_q != CAUSE_NONE) ? code_q : (noise_lvl_i ? CAUSE_NOISE : CAUSE_NONE);
  assign irq_o   = irq_q;

  AST_IRQ_ON_POST: assert property (@(posedge clk) disable iff (!rst_n)
    (new_rank != 3'd0) |=> irq_q); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && new_rank == 3'd0) |=> !irq_q); // R3
  AST_LIG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    post_lig_i |=> (code_q == CAUSE_LIG)); // R10
  AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(code_q)); // R2
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_pkg::*;
#(
  parameter int TICKS_PER_MIN  = 1966080,
  parameter int WIN_SLOTS      = 15,
  parameter int SLOT_W         = 6,
  parameter int DIS_LOCK_TICKS = 49152,
  parameter int LIG_LOCK_TICKS = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       noise_hi,
  input  logic       lig_evt,
  input  logic       dis_evt,
  input  logic       dist_evt,
  input  logic       mask_dis,
  input  logic [1:0] min_sel,
  input  logic       clr_stat,
  input  logic       cause_rd,
  output logic [3:0] cause,
  output logic       irq
);
  localparam int SUM_W = $clog2(WIN_SLOTS * ((1 << SLOT_W) - 1) + 1);

  logic             locked, lig_acc, dis_acc, lig_gate, clr_prev_q, clr_rise;
  logic [SUM_W-1:0] win_sum;

  assign lig_acc  = lig_evt && !locked;
  assign dis_acc  = dis_evt && !locked && !lig_evt;
  assign lig_gate = (32'(win_sum) + 32'd1) >= 32'(min_lightning(min_sel));
  assign clr_rise = clr_stat && !clr_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) clr_prev_q <= 1'b1;
    else        clr_prev_q <= clr_stat;
  end

  evt_lockout #(
    .DIS_TICKS(DIS_LOCK_TICKS),
    .LIG_TICKS(LIG_LOCK_TICKS)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .ld_lig_i(lig_acc), .ld_dis_i(dis_acc), .locked_o(locked)
  );

  evt_window #(
    .TICKS_PER_MIN(TICKS_PER_MIN),
    .WIN_SLOTS(WIN_SLOTS),
    .SLOT_W(SLOT_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .inc_i(lig_acc), .clr_i(clr_rise), .sum_o(win_sum)
  );

  evt_cause u_cause (
    .clk(clk), .rst_n(rst_n), .rd_i(cause_rd), .noise_lvl_i(noise_hi),
    .post_lig_i(lig_acc && lig_gate), .post_dis_i(dis_acc && !mask_dis),
    .post_dist_i(dist_evt), .cause_o(cause), .irq_o(irq)
  );

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_evt && mask_dis && !lig_evt && !noise_hi && !dist_evt && !cause_rd)
      |=> $stable(irq)); // R5
  AST_LOCKED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clr_rise && !tick) |=> $stable(win_sum)); // R8
endmodule

// File: tb/tb_evt_irq_ctrl.sv
module tb_evt_irq_ctrl;
  localparam int TPM = 20, WIN = 15, DISL = 6, LIGL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, noise_hi = 1'b0, lig_evt = 1'b0, dis_evt = 1'b0, dist_evt = 1'b0;
  logic mask_dis = 1'b0, clr_stat = 1'b1, cause_rd = 1'b0;
  logic [1:0] min_sel = 2'b00;
  logic [3:0] cause;
  logic irq;

  int nchk = 0, nfail = 0;
  bit chk_en = 1'b0;
  string cur_req = "R1";

  evt_irq_ctrl #(.TICKS_PER_MIN(TPM), .WIN_SLOTS(WIN), .SLOT_W(6),
                 .DIS_LOCK_TICKS(DISL), .LIG_LOCK_TICKS(LIGL)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .noise_hi(noise_hi), .lig_evt(lig_evt),
    .dis_evt(dis_evt), .dist_evt(dist_evt), .mask_dis(mask_dis), .min_sel(min_sel),
    .clr_stat(clr_stat), .cause_rd(cause_rd), .cause(cause), .irq(irq));

  always #10 clk = ~clk;

  // behavioural reference model
  int m_lock = 0, m_tcnt = 0, m_min = 0;
  int stamps[$];
  int m_code = 0;
  bit m_irq = 0, m_noise_prev = 0, m_clr_prev = 1;

  function automatic int need(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 5 : (s == 2'b10) ? 9 : 16;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 0; m_tcnt = 0; m_min = 0; stamps.delete();
      m_code = 0; m_irq = 0; m_noise_prev = 0; m_clr_prev = 1;
    end else begin
      bit locked, la, da, adv;
      int inwin, curp, newp;
      locked = (m_lock > 0);
      la = lig_evt && !locked;
      da = dis_evt && !locked && !lig_evt;
      inwin = 0;
      foreach (stamps[k]) if (stamps[k] > m_min - WIN) inwin++;
      adv = tick && (m_tcnt == TPM - 1);
      newp = 0;
      if (la && inwin + 1 >= need(min_sel)) newp = 4;
      else if (da && !mask_dis)             newp = 3;
      else if (noise_hi && !m_noise_prev)   newp = 2;
      else if (dist_evt)                    newp = 1;
      if (la) stamps.push_back(adv ? m_min + 1 : m_min);
      if (tick) m_tcnt = adv ? 0 : m_tcnt + 1;
      if (adv) m_min++;
      if (clr_stat && !m_clr_prev) stamps.delete();
      m_clr_prev = clr_stat;
      if (la) m_lock = LIGL;
      else if (da) m_lock = DISL;
      else if (tick && m_lock > 0) m_lock--;
      curp = (m_code == 8) ? 4 : (m_code == 4) ? 3 : (m_code == 1) ? 2 : (m_irq ? 1 : 0);
      if (cause_rd) curp = 0;
      if (newp > 0 && newp >= curp) begin
        m_code = (newp == 4) ? 8 : (newp == 3) ? 4 : (newp == 2) ? 1 : 0;
        m_irq = 1;
      end else if (cause_rd) begin
        m_code = 0; m_irq = 0;
      end
      m_noise_prev = noise_hi;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      int ec;
      ec = (m_code != 0) ? m_code : (noise_hi ? 1 : 0);
      nchk++;
      if (cause !== 4'(ec) || irq !== m_irq) begin
        nfail++;
        $display("FAIL %s model: cause=%b irq=%b expected cause=%b irq=%b",
                 cur_req, cause, irq, 4'(ec), m_irq);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #5;
  endtask

  task automatic look(input string tag, input logic [3:0] c, input logic i);
    #5;
    nchk++;
    if (cause !== c || irq !== i) begin
      nfail++;
      $display("FAIL %s cause=%b irq=%b expected cause=%b irq=%b", tag, cause, irq, c, i);
    end
    #1;
  endtask

  task automatic pulse_lig();  lig_evt = 1;  cyc(); lig_evt = 0;  endtask
  task automatic pulse_dis();  dis_evt = 1;  cyc(); dis_evt = 0;  endtask
  task automatic pulse_dist(); dist_evt = 1; cyc(); dist_evt = 0; endtask
  task automatic pulse_rd();   cause_rd = 1; cyc(); cause_rd = 0; endtask
  task automatic idle(input int n); repeat (n) cyc(); endtask
  task automatic clear_hist(); clr_stat = 0; cyc(); clr_stat = 1; cyc(); endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1; chk_en = 1;
    cur_req = "R1"; look("R1", 4'b0000, 1'b0);

    cur_req = "R2";
    cyc(); pulse_lig(); look("R2", 4'b1000, 1'b1);
    idle(6); pulse_rd(); look("R3", 4'b0000, 1'b0);
    pulse_dis(); look("R2", 4'b0100, 1'b1);
    idle(8); pulse_rd();
    pulse_dist(); look("R2", 4'b0000, 1'b1);
    pulse_rd(); look("R3", 4'b0000, 1'b0);

    cur_req = "R4";
    noise_hi = 1; cyc(); look("R4", 4'b0001, 1'b1);
    pulse_rd(); look("R4", 4'b0001, 1'b0);
    idle(4); look("R4", 4'b0001, 1'b0);
    noise_hi = 0; cyc(); look("R4", 4'b0000, 1'b0);

    cur_req = "R5";
    mask_dis = 1; pulse_dis(); look("R5", 4'b0000, 1'b0);
    idle(8); mask_dis = 0;

    cur_req = "R10";
    noise_hi = 1; dis_evt = 1; cyc(); dis_evt = 0; look("R10", 4'b0100, 1'b1);
    idle(8); pulse_lig(); look("R10", 4'b1000, 1'b1);
    idle(6); pulse_dis(); look("R10", 4'b1000, 1'b1);
    pulse_dist(); look("R10", 4'b1000, 1'b1);
    noise_hi = 0; idle(8);
    cause_rd = 1; lig_evt = 1; cyc(); cause_rd = 0; lig_evt = 0;
    look("R3", 4'b1000, 1'b1);
    idle(6); pulse_rd();

    cur_req = "R6";
    clear_hist(); min_sel = 2'b01;
    for (int k = 1; k <= 4; k++) begin pulse_lig(); look("R6", 4'b0000, 1'b0); idle(5); end
    pulse_lig(); look("R6", 4'b1000, 1'b1); idle(5); pulse_rd();
    pulse_lig(); look("R6", 4'b1000, 1'b1); idle(5); pulse_rd();

    cur_req = "R9";
    clear_hist(); pulse_lig(); look("R9", 4'b0000, 1'b0); idle(5);

    cur_req = "R6";
    clear_hist(); min_sel = 2'b10;
    for (int k = 1; k <= 8; k++) begin pulse_lig(); look("R6", 4'b0000, 1'b0); idle(5); end
    pulse_lig(); look("R6", 4'b1000, 1'b1); idle(5); pulse_rd();
    clear_hist(); min_sel = 2'b11;
    for (int k = 1; k <= 15; k++) begin pulse_lig(); look("R6", 4'b0000, 1'b0); idle(5); end
    pulse_lig(); look("R6", 4'b1000, 1'b1); idle(5); pulse_rd();

    cur_req = "R7";
    clear_hist(); min_sel = 2'b01;
    for (int k = 1; k <= 4; k++) begin pulse_lig(); idle(5); end
    idle(TPM * (WIN + 1) + 5);
    for (int k = 1; k <= 4; k++) begin pulse_lig(); look("R7", 4'b0000, 1'b0); idle(5); end
    pulse_lig(); look("R7", 4'b1000, 1'b1); idle(5); pulse_rd();

    cur_req = "R8";
    clear_hist(); min_sel = 2'b00;
    pulse_dis(); look("R8", 4'b0100, 1'b1);
    pulse_rd(); idle(1);
    pulse_lig(); look("R8", 4'b0000, 1'b0);
    idle(8); pulse_lig(); look("R8", 4'b1000, 1'b1);
    pulse_rd(); pulse_dis(); look("R8", 4'b0000, 1'b0);
    idle(6);
    tick = 0; pulse_dis(); pulse_rd();
    idle(20); pulse_lig(); look("R8", 4'b0000, 1'b0);
    tick = 1; idle(8);
    lig_evt = 1; dis_evt = 1; cyc(); lig_evt = 0; dis_evt = 0;
    look("R8", 4'b1000, 1'b1);
    idle(6); pulse_rd(); idle(3);

    chk_en = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule